// File: doc/BRIEF.md
# Regulator Startup Sequencing Controller

This block is the control sequencer of a multiphase buck regulator. It takes the regulator from power-on, through calibration, phase detection and configuration, driver bring-up, an optional wait for the first voltage command, a boost-capacitor refresh and a digital soft-start ramp, into regulation. It also takes the regulator back out again. Supply-good flags, the enable pin, the external driver's ready line and a fault latch from the protection logic can interrupt the sequence at any point. The analog loop, the serial command decoder and the PWM modulators sit around it and talk to it through simple flags and codes.

The outputs are a DAC target code in 5 mV steps, the driver-enable line, a ready flag and a two-bit drive mode for every phase. The states are Off, Calibrate, Configure, DriverOn, BootCheck, WaitCommand, Refresh, Ramp, Regulate and Latched. The normal transitions are:

- Off to Calibrate on enable.
- Calibrate to Configure on calibration-done.
- Configure to DriverOn on configuration-done.
- DriverOn to BootCheck when the driver reports ready.
- BootCheck to Refresh when the boot code is nonzero, or to WaitCommand when it is zero.
- WaitCommand to Refresh on the command strobe.
- Refresh to Ramp when the refresh timer expires.
- Ramp to Regulate when the code reaches the target.
- Ramp or Regulate to Latched on a fault.

Every state has a way back to Off, described in R1 and R7.

Top module: `vr_seq_ctrl`

## Requirements
- R1: While either `vcc_ok` or `vin_ok` is low, the controller is in Off (or enters it at the next edge). Off drives `drv_en` low, `ready` low and `dac_code` to 0. Off is left only when both flags are high and `en` is high.
- R2: From enable, the order is fixed: Calibrate waits for `cal_done`, then Configure waits for `cfg_done`, then `drv_en` is raised and the controller waits for `drv_rdy`. `drv_en` stays high from then on until Off is entered.
- R3: A latched boot code that is nonzero becomes the ramp target and leads straight to Refresh. A boot code of 0 holds the controller in WaitCommand, with `dac_code` at 0 and `drv_en` high, until `vid_strobe`. The `vid_code` value present with that strobe becomes the target.
- R4: In Ramp, `dac_code` rises from 0 once every STEP_CYC clocks. Each step is 1 LSB when `fast_slew` is 0 and FAST_STEP LSBs (4 by default) when it is 1. The code saturates exactly at the target and never passes it.
- R5: Each two-bit field i of `ph_mode` (bits 2i+1:2i) uses this encoding: 0 low, 1 mid, 2 high impedance, 3 active. The fields are mid in Off and in the pre-ramp driver states, and high impedance in Calibrate and Configure. A phase becomes active only after its `pwm_pulse` bit is seen in Ramp or Regulate. Pulses in any other state have no effect.
- R6: `ready` rises RDY_DLY clocks after Regulate is entered, with `dac_code` equal to the target. It falls in the same cycle that Regulate is left.
- R7: When `en` is low in any state, the next state is Off. When `drv_rdy` is low in any state after DriverOn, the next state is also Off.
- R8: A `fault` in Ramp or Regulate enters Latched. Latched drives every phase low and `ready` low, holds `dac_code`, and keeps `drv_en` high. It is left only through R1 or R7.
- R9: `boot_code` is captured once, when `cfg_done` arrives in Configure. Later changes to it are ignored, across enable cycles, until a supply loss.
- R10: Refresh lasts exactly REFRESH_CYC clocks, with `dac_code` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Controller supply above its undervoltage threshold |
| vin_ok | input | 1 | Input-voltage supply above its undervoltage threshold |
| en | input | 1 | Enable pin |
| drv_rdy | input | 1 | External driver releases the enable line (high = ready) |
| cal_done | input | 1 | Calibration finished pulse |
| cfg_done | input | 1 | Phase detection and configuration finished pulse |
| boot_code | input | DAC_W | Decoded boot-voltage code, 5 mV per LSB |
| vid_strobe | input | 1 | First voltage command received |
| vid_code | input | DAC_W | Voltage code carried by that command |
| fast_slew | input | 1 | Select the fast soft-start rate |
| pwm_pulse | input | NPH | Per-phase first-pulse indication from the modulators |
| fault | input | 1 | Latched fault from the protection block |
| dac_code | output | DAC_W | DAC target code |
| drv_en | output | 1 | Driver-enable output |
| ready | output | 1 | Output-in-regulation flag |
| ph_mode | output | 2*NPH | Per-phase drive mode |

## Verification
The hardest case to reach is the retained boot code. It only shows after a full sequence has finished, enable has been toggled with the supplies still good, and `boot_code` has been changed in between. The stimulus does exactly that, and a second ramp must end at the old code. It then drops a supply and repeats with a zero code, which must now be captured and must park the sequencer in WaitCommand. Latched is reached by raising `fault` after phases have gone active. This shows that the active modes give way to low while the code is held.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;
    typedef enum logic [3:0] {
        ST_OFF, ST_CAL, ST_POC, ST_DRV, ST_BOOT,
        ST_VID, ST_REFR, ST_RAMP, ST_REG, ST_LATCH
    } seq_st_e;

    localparam logic [1:0] PM_LOW = 2'd0;
    localparam logic [1:0] PM_MID = 2'd1;
    localparam logic [1:0] PM_HIZ = 2'd2;
    localparam logic [1:0] PM_ACT = 2'd3;
endpackage

// File: rtl/vr_dac_ramp.sv
module vr_dac_ramp #(
    parameter int DAC_W     = 8,
    parameter int STEP_CYC  = 4,
    parameter int FAST_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             fast,
    input  logic [DAC_W-1:0] target,
    output logic [DAC_W-1:0] dac,
    output logic             at_target
);
    localparam int PW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(STEP_CYC - 1);

    logic [PW-1:0]    presc_q;
    logic [DAC_W-1:0] dac_q;
    logic [DAC_W-1:0] nxt;
    logic [DAC_W:0]   step;
    logic [DAC_W:0]   room;

    always_comb begin
        step = fast ? (DAC_W+1)'(FAST_STEP) : (DAC_W+1)'(1);
        room = {1'b0, target} - {1'b0, dac_q};
        if (dac_q >= target || room <= step) nxt = target;
        else                                 nxt = dac_q + step[DAC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            dac_q   <= '0;
        end else if (clr) begin
            presc_q <= '0;
            dac_q   <= '0;
        end else if (run) begin
            if (presc_q == P_LAST) begin
                presc_q <= '0;
                dac_q   <= nxt;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    assign dac       = dac_q;
    assign at_target = (dac_q == target);

    p_no_overshoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dac_q <= target) |=> dac_q <= $past(target));
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (dac_q >= $past(dac_q)) &&
                         ({1'b0, dac_q} <= {1'b0, $past(dac_q)} + (DAC_W+1)'(FAST_STEP)));
endmodule

// File: rtl/vr_rdy_delay.sv
module vr_rdy_delay #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic ready
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] C_END = CW'(DLY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!arm)           cnt_q <= '0;
        else if (cnt_q != C_END) cnt_q <= cnt_q + 1'b1;
    end

    assign ready = arm && (cnt_q == C_END);

    p_ready_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(arm));
endmodule

// File: rtl/vr_phase_mode.sv
module vr_phase_mode
    import vr_seq_pkg::*;
#(
    parameter int NPH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [1:0]       base_mode,
    input  logic [NPH-1:0]   pulse,
    output logic [2*NPH-1:0] mode
);
    logic [NPH-1:0] fired_q;

    for (genvar g = 0; g < NPH; g++) begin : g_ph
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fired_q[g] <= 1'b0;
            else        fired_q[g] <= running & (fired_q[g] | pulse[g]);
        end
        assign mode[2*g +: 2] = (running && fired_q[g]) ? PM_ACT : base_mode;
    end

    p_fired_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> fired_q == '0);
endmodule

// File: rtl/vr_seq_ctrl.sv
module vr_seq_ctrl
    import vr_seq_pkg::*;
#(
    parameter int DAC_W       = 8,
    parameter int NPH         = 4,
    parameter int STEP_CYC    = 4,
    parameter int FAST_STEP   = 4,
    parameter int REFRESH_CYC = 6,
    parameter int RDY_DLY     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vcc_ok,
    input  logic             vin_ok,
    input  logic             en,
    input  logic             drv_rdy,
    input  logic             cal_done,
    input  logic             cfg_done,
    input  logic [DAC_W-1:0] boot_code,
    input  logic             vid_strobe,
    input  logic [DAC_W-1:0] vid_code,
    input  logic             fast_slew,
    input  logic [NPH-1:0]   pwm_pulse,
    input  logic             fault,
    output logic [DAC_W-1:0] dac_code,
    output logic             drv_en,
    output logic             ready,
    output logic [2*NPH-1:0] ph_mode
);
    localparam int RW = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
    localparam logic [RW-1:0] R_LAST = RW'(REFRESH_CYC - 1);

    seq_st_e          st_q, st_nxt;
    logic [RW-1:0]    rcnt_q;
    logic [DAC_W-1:0] boot_q, tgt_q;
    logic             boot_vld_q;
    logic             sup_ok, post_drv, running, clr_dac, at_tgt;
    logic [1:0]       base_mode;

    assign sup_ok   = vcc_ok && vin_ok;
    assign post_drv = st_q inside {ST_BOOT, ST_VID, ST_REFR, ST_RAMP, ST_REG, ST_LATCH};
    assign running  = st_q inside {ST_RAMP, ST_REG};
    assign clr_dac  = !(st_q inside {ST_RAMP, ST_REG, ST_LATCH});

    // next-state selection
    always_comb begin
        st_nxt = st_q;
        if (!sup_ok)                     st_nxt = ST_OFF;
        else if (st_q != ST_OFF && !en)  st_nxt = ST_OFF;
        else if (post_drv && !drv_rdy)   st_nxt = ST_OFF;
        else if (running && fault)       st_nxt = ST_LATCH;
        else begin
            unique case (st_q)
                ST_OFF:   if (en)       st_nxt = ST_CAL;
                ST_CAL:   if (cal_done) st_nxt = ST_POC;
                ST_POC:   if (cfg_done) st_nxt = ST_DRV;
                ST_DRV:   if (drv_rdy)  st_nxt = ST_BOOT;
                ST_BOOT:  st_nxt = (boot_q == '0) ? ST_VID : ST_REFR;
                ST_VID:   if (vid_strobe) st_nxt = ST_REFR;
                ST_REFR:  if (rcnt_q == R_LAST) st_nxt = ST_RAMP;
                ST_RAMP:  if (at_tgt)   st_nxt = ST_REG;
                ST_REG:   st_nxt = ST_REG;
                ST_LATCH: st_nxt = ST_LATCH;
                default:  st_nxt = ST_OFF;
            endcase
        end
    end

    // state register and sequencing storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_OFF;
            rcnt_q     <= '0;
            boot_q     <= '0;
            boot_vld_q <= 1'b0;
            tgt_q      <= '0;
        end else begin
            st_q   <= st_nxt;
            rcnt_q <= (st_q == ST_REFR) ? rcnt_q + 1'b1 : '0;
            if (!sup_ok)
                boot_vld_q <= 1'b0;
            else if (st_q == ST_POC && cfg_done && !boot_vld_q) begin
                boot_q     <= boot_code;
                boot_vld_q <= 1'b1;
            end
            if (st_q == ST_BOOT)                    tgt_q <= boot_q;
            else if (st_q == ST_VID && vid_strobe)  tgt_q <= vid_code;
        end
    end

    // outputs
    always_comb begin
        drv_en = st_q inside {ST_DRV, ST_BOOT, ST_VID, ST_REFR, ST_RAMP, ST_REG, ST_LATCH};
        unique case (st_q)
            ST_CAL, ST_POC: base_mode = PM_HIZ;
            ST_LATCH:       base_mode = PM_LOW;
            default:        base_mode = PM_MID;
        endcase
    end

    vr_dac_ramp #(.DAC_W(DAC_W), .STEP_CYC(STEP_CYC), .FAST_STEP(FAST_STEP)) ramp_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_dac), .run(st_q == ST_RAMP),
        .fast(fast_slew), .target(tgt_q), .dac(dac_code), .at_target(at_tgt)
    );

    vr_rdy_delay #(.DLY(RDY_DLY)) rdy_i (
        .clk(clk), .rst_n(rst_n), .arm(st_q == ST_REG), .ready(ready)
    );

    vr_phase_mode #(.NPH(NPH)) phase_i (
        .clk(clk), .rst_n(rst_n), .running(running), .base_mode(base_mode),
        .pulse(pwm_pulse), .mode(ph_mode)
    );

    p_supply_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> st_q == ST_OFF);
    p_en_low_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> st_q == ST_OFF);
    p_ready_at_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> dac_code == tgt_q);
    p_boot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_vld_q && sup_ok) |=> $stable(boot_q));
    p_latch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH) |-> (ph_mode == '0) && !ready && drv_en);
    p_off_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |-> ph_mode == {NPH{PM_MID}});
    p_refresh_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REFR) |-> dac_code == '0);
endmodule

// File: tb/vr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module vr_seq_ctrl_tb_top;
    localparam int DAC_W = 8, NPH = 4, STEP_CYC = 4, FAST_STEP = 4;
    localparam int REFRESH_CYC = 6, RDY_DLY = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vcc_ok = 0, vin_ok = 0, en = 0, drv_rdy = 0, cal_done = 0, cfg_done = 0;
    logic [DAC_W-1:0] boot_code = 8'd40, vid_code = '0;
    logic vid_strobe = 0, fast_slew = 0, fault = 0;
    logic [NPH-1:0] pwm_pulse = '0;
    logic [DAC_W-1:0] dac_code;
    logic drv_en, ready;
    logic [2*NPH-1:0] ph_mode;

    always #2 clk = ~clk;

    vr_seq_ctrl #(.DAC_W(DAC_W), .NPH(NPH), .STEP_CYC(STEP_CYC), .FAST_STEP(FAST_STEP),
                  .REFRESH_CYC(REFRESH_CYC), .RDY_DLY(RDY_DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vin_ok(vin_ok), .en(en),
        .drv_rdy(drv_rdy), .cal_done(cal_done), .cfg_done(cfg_done),
        .boot_code(boot_code), .vid_strobe(vid_strobe), .vid_code(vid_code),
        .fast_slew(fast_slew), .pwm_pulse(pwm_pulse), .fault(fault),
        .dac_code(dac_code), .drv_en(drv_en), .ready(ready), .ph_mode(ph_mode)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    localparam int M_OFF = 0, M_CAL = 1, M_CFG = 2, M_DRV = 3, M_BOOT = 4,
                   M_VID = 5, M_REFR = 6, M_RAMP = 7, M_REG = 8, M_LATCH = 9;
    int m_st = M_OFF, m_dac = 0, m_pre = 0, m_tgt = 0, m_boot = 0, m_rc = 0, m_rdc = 0;
    bit m_bvld = 0;
    bit m_fired [NPH];

    function automatic bit m_run(input int s);
        return (s == M_RAMP) || (s == M_REG);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = M_OFF; m_dac = 0; m_pre = 0; m_tgt = 0; m_boot = 0;
            m_rc = 0; m_rdc = 0; m_bvld = 0;
            foreach (m_fired[p]) m_fired[p] = 0;
        end else begin
            int ns, nd, np, nt, step;
            bit sup, postd;
            sup = vcc_ok && vin_ok;
            postd = (m_st >= M_BOOT);
            ns = m_st;
            if (!sup) ns = M_OFF;
            else if (m_st != M_OFF && !en) ns = M_OFF;
            else if (postd && !drv_rdy) ns = M_OFF;
            else if (m_run(m_st) && fault) ns = M_LATCH;
            else case (m_st)
                M_OFF:  if (en) ns = M_CAL;
                M_CAL:  if (cal_done) ns = M_CFG;
                M_CFG:  if (cfg_done) ns = M_DRV;
                M_DRV:  if (drv_rdy) ns = M_BOOT;
                M_BOOT: ns = (m_boot == 0) ? M_VID : M_REFR;
                M_VID:  if (vid_strobe) ns = M_REFR;
                M_REFR: if (m_rc == REFRESH_CYC - 1) ns = M_RAMP;
                M_RAMP: if (m_dac == m_tgt) ns = M_REG;
                default: ;
            endcase
            nd = m_dac; np = m_pre; nt = m_tgt;
            if (!(m_run(m_st) || m_st == M_LATCH)) begin nd = 0; np = 0; end
            else if (m_st == M_RAMP) begin
                if (m_pre == STEP_CYC - 1) begin
                    step = fast_slew ? FAST_STEP : 1;
                    np = 0;
                    nd = (m_dac + step > m_tgt) ? m_tgt : m_dac + step;
                end else np = m_pre + 1;
            end
            if (m_st == M_BOOT) nt = m_boot;
            else if (m_st == M_VID && vid_strobe) nt = vid_code;
            if (!sup) m_bvld = 0;
            else if (m_st == M_CFG && cfg_done && !m_bvld) begin
                m_boot = boot_code; m_bvld = 1;
            end
            m_rc  = (m_st == M_REFR) ? m_rc + 1 : 0;
            m_rdc = (m_st != M_REG) ? 0 : ((m_rdc < RDY_DLY) ? m_rdc + 1 : m_rdc);
            for (int p = 0; p < NPH; p++)
                m_fired[p] = m_run(m_st) && (m_fired[p] || pwm_pulse[p]);
            m_st = ns; m_dac = nd; m_pre = np; m_tgt = nt;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_ph, base;
            bit e_drv, e_rdy;
            e_drv = (m_st >= M_DRV);
            e_rdy = (m_st == M_REG) && (m_rdc == RDY_DLY);
            base = (m_st == M_CAL || m_st == M_CFG) ? 2 : (m_st == M_LATCH) ? 0 : 1;
            e_ph = 0;
            for (int p = 0; p < NPH; p++)
                e_ph |= ((m_run(m_st) && m_fired[p]) ? 3 : base) << (2 * p);
            chk(int'(dac_code) == m_dac, "R4 dac_code", int'(dac_code), m_dac);
            chk(drv_en == e_drv, "R2 drv_en", int'(drv_en), int'(e_drv));
            chk(ready == e_rdy, "R6 ready", int'(ready), int'(e_rdy));
            chk(int'(ph_mode) == e_ph, "R5 ph_mode", int'(ph_mode), e_ph);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_cal(); cal_done = 1; tick(1); cal_done = 0; endtask
    task automatic pulse_cfg(); cfg_done = 1; tick(1); cfg_done = 0; endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!ready && n < 3000) begin tick(1); n++; end
        chk(ready == 1'b1, req, int'(ready), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        chk(dac_code == 0 && !drv_en && !ready, "R1 reset outputs", int'(dac_code), 0);
        chk(ph_mode == 8'h55, "R5 reset mid", int'(ph_mode), 'h55);

        // one supply only: stays off
        vcc_ok = 1; en = 1; tick(5);
        chk(drv_en == 0 && ph_mode == 8'h55, "R1 half supply", int'(drv_en), 0);
        vin_ok = 1; tick(2);
        chk(ph_mode == 8'hAA, "R2 calibrate hiz", int'(ph_mode), 'hAA);
        tick(3); pulse_cal(); tick(2);
        chk(drv_en == 0, "R2 no drv before cfg", int'(drv_en), 0);
        pulse_cfg();
        chk(drv_en == 1 && ph_mode == 8'h55, "R2 drv_en mid", int'(drv_en), 1);
        tick(4); drv_rdy = 1; tick(2);
        pwm_pulse = 4'b0010; tick(1); pwm_pulse = '0;   // refresh: ignored
        tick(REFRESH_CYC - 2);
        chk(dac_code == 0, "R10 refresh holds zero", int'(dac_code), 0);
        tick(20);
        pwm_pulse = 4'b0101; tick(1); pwm_pulse = '0;
        tick(1);
        chk(ph_mode == 8'h77, "R5 active after pulse", int'(ph_mode), 'h77);
        wait_ready("R6 ready slow ramp");
        chk(dac_code == 40, "R3 boot target", int'(dac_code), 40);

        fault = 1; tick(1); fault = 0; tick(1);
        chk(ph_mode == 0 && !ready && dac_code == 40, "R8 latched", int'(ph_mode), 0);
        tick(5);
        chk(drv_en == 1 && dac_code == 40, "R8 latch holds", int'(dac_code), 40);
        en = 0; tick(2);
        chk(drv_en == 0 && ph_mode == 8'h55, "R7 enable low", int'(drv_en), 0);

        // boot code change ignored, fast ramp
        boot_code = 8'd0; fast_slew = 1; en = 1;
        tick(2); pulse_cal(); tick(1); pulse_cfg(); tick(1);
        wait_ready("R4 fast ramp ready");
        chk(dac_code == 40, "R9 boot code retained", int'(dac_code), 40);
        drv_rdy = 0; tick(2);
        chk(drv_en == 0 && !ready, "R7 driver low", int'(drv_en), 0);
        drv_rdy = 1;

        // supply loss: new boot code of zero captured
        vin_ok = 0; tick(2);
        chk(drv_en == 0 && dac_code == 0, "R1 supply drop", int'(dac_code), 0);
        vin_ok = 1; fast_slew = 0; tick(2);
        pulse_cal(); tick(1); pulse_cfg(); tick(30);
        chk(drv_en == 1 && dac_code == 0 && !ready, "R3 waiting command", int'(dac_code), 0);
        vid_code = 8'd25; vid_strobe = 1; tick(1); vid_strobe = 0; vid_code = 8'd99;
        wait_ready("R6 ready after command");
        chk(dac_code == 25, "R3 command target", int'(dac_code), 25);
        tick(5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule